// File: doc/BRIEF.md
# Pattern-Matching Event Counter Bank

This block watches a wide bus of sampled debug signals and turns bit patterns on that bus into hardware events. Each event is defined by a mask/match pair. An event is true when every bit the mask selects has the value that the match word gives. A bank of counters then counts these events. Each counter picks one event. It can count occurrences (rising transitions of the condition) or duration (cycles the condition holds). It counts up or down, can be preset, and saturates with sticky flags.

The sample bus is split into lanes, and each lane comes with a native-clock activity indication. A lane whose clock is reported off keeps its last captured value. Its stale or floating bits therefore cannot create events.

A snapshot command copies every counter at once into a shadow bank. The shadow bank can be read through the register port. It can also be pushed out as a short stream of beats tagged with a fixed master identifier.

Top module: `evt_count_bank`

## Requirements
- R1: Event e is true when ((sample XOR match[e]) AND mask[e]) is all zeros; an all-zero mask makes the event always true.
- R2: In occurrence mode (ctrl bit2 = 0) an enabled counter adds one per 0-to-1 transition of its selected event, not per cycle.
- R3: In duration mode (ctrl bit2 = 1) an enabled counter changes by one on every cycle its selected event is true.
- R4: Ctrl bit0 enables a counter and bit1 selects down counting; a disabled counter holds its value. Ctrl is at address 0x20+n.
- R5: A counting up saturates at all-ones and sets the sticky overflow flag (ctrl read bit8). A counting down saturates at zero and sets the sticky underflow flag (ctrl read bit9). A write to the counter's ctrl register clears both flags.
- R6: A write to address 0x30+n presets counter n to the written value. It takes priority over a count in the same cycle, and the counter is readable at the same address.
- R7: A lane whose activity input is low keeps its previously captured sample bits; capture resumes the cycle after the lane is active again. Lanes are 8 bits wide, and lane 0 is bits 7:0.
- R8: Writing bit0 of the command register (0x50) copies all counters in the same cycle into snapshot registers, read at 0x40+n. Later counter changes do not alter them.
- R9: Writing bit1 of the command register takes a snapshot and then emits one beat per counter on consecutive cycles, with indices 0,1,2,… and the snapshot values. Every beat carries master ID 2.
- R10: After reset all masks, matches, controls, counters and snapshots read zero and no stream beat is valid.
- R11: Ctrl bits 7:4 select the event driving the counter; a value at or above the number of events selects a never-true event. Masks are at 0x00+e and matches at 0x10+e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_in | input | 32 | Sampled debug signals |
| lane_alive | input | 4 | Native-clock activity of each 8-bit lane |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address, region in bits 7:4 and index in bits 3:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from the address) |
| st_valid | output | 1 | Stream beat valid |
| st_id | output | 4 | Stream master identifier |
| st_idx | output | 2 | Counter index of the beat |
| st_data | output | 16 | Snapshot value of the beat |

## Verification
On every cycle, the embedded assertions check these properties: counter saturation at the upper limit, persistence of the sticky flags, hold of a disabled counter, freezing of a dead lane's sample bits, and strictly incrementing stream indices. Only the bench scenarios can show the rest, because each of them depends on a sequence of stimulus and an exact final count. These are the mask/match decisions across the vector table, occurrence counts differing from duration counts on the same pulse train, and underflow with flag clearing. The same holds for preset priority, snapshot coherence after preset, stream contents, and the effect of an out-of-range event selector.

// File: rtl/evt_count_bank.sv
module evt_count_bank #(
  parameter int SW    = 32,
  parameter int LANES = 4,
  parameter int NEV   = 4,
  parameter int NCTR  = 4,
  parameter int CW    = 16,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int IDW   = 4,
  parameter logic [IDW-1:0] MASTER_ID = 4'd2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SW-1:0]            smp_in,
  input  logic [LANES-1:0]         lane_alive,
  input  logic                     reg_we,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  output logic                     st_valid,
  output logic [IDW-1:0]           st_id,
  output logic [$clog2(NCTR)-1:0]  st_idx,
  output logic [CW-1:0]            st_data
);
  localparam int LW = SW / LANES;
  localparam int IW = $clog2(NCTR);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [3:0] region, idx;
  assign region = reg_addr[AW-1:4];
  assign idx    = reg_addr[3:0];

  logic [SW-1:0]  s_q;
  logic [SW-1:0]  mask_q [NEV];
  logic [SW-1:0]  match_q[NEV];
  logic [NEV-1:0] ev, ev_q;
  logic [15:0]    lvl_pad, rise_pad;

  logic           en_q[NCTR], dn_q[NCTR], dur_q[NCTR], ovf_q[NCTR], unf_q[NCTR];
  logic [3:0]     sel_q[NCTR];
  logic [CW-1:0]  cnt_q[NCTR], snap_q[NCTR];
  logic [NCTR-1:0] ld, cw;

  logic cmd_wr, snap_cmd, stream_cmd, st_busy;
  logic [IW-1:0] st_ptr;
  assign cmd_wr     = reg_we && region == 4'd5;
  assign snap_cmd   = cmd_wr && (reg_wdata[0] || reg_wdata[1]);
  assign stream_cmd = cmd_wr && reg_wdata[1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) s_q[l*LW +: LW] <= '0;
      else if (lane_alive[l]) s_q[l*LW +: LW] <= smp_in[l*LW +: LW];

    a_r7_dead_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_alive[l] |=> $stable(s_q[l*LW +: LW]));
  end

  for (genvar e = 0; e < NEV; e++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        mask_q[e]  <= '0;
        match_q[e] <= '0;
      end else if (reg_we && idx == 4'(e)) begin
        if (region == 4'd0) mask_q[e]  <= reg_wdata[SW-1:0];
        if (region == 4'd1) match_q[e] <= reg_wdata[SW-1:0];
      end
    assign ev[e] = ((s_q ^ match_q[e]) & mask_q[e]) == '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev_q <= '0;
    else ev_q <= ev;

  always_comb begin
    lvl_pad  = '0;
    rise_pad = '0;
    lvl_pad[NEV-1:0]  = ev;
    rise_pad[NEV-1:0] = ev & ~ev_q;
  end

  for (genvar c = 0; c < NCTR; c++) begin : g_ctr
    logic hit;
    assign ld[c] = reg_we && region == 4'd3 && idx == 4'(c);
    assign cw[c] = reg_we && region == 4'd2 && idx == 4'(c);
    assign hit   = en_q[c] && (dur_q[c] ? lvl_pad[sel_q[c]] : rise_pad[sel_q[c]]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en_q[c] <= 1'b0; dn_q[c] <= 1'b0; dur_q[c] <= 1'b0; sel_q[c] <= '0;
        ovf_q[c] <= 1'b0; unf_q[c] <= 1'b0; cnt_q[c] <= '0; snap_q[c] <= '0;
      end else begin
        if (ld[c]) cnt_q[c] <= reg_wdata[CW-1:0];
        else if (hit) begin
          if (dn_q[c]) begin
            if (cnt_q[c] == '0) unf_q[c] <= 1'b1;
            else cnt_q[c] <= cnt_q[c] - 1'b1;
          end else begin
            if (cnt_q[c] == CMAX) ovf_q[c] <= 1'b1;
            else cnt_q[c] <= cnt_q[c] + 1'b1;
          end
        end
        if (cw[c]) begin
          en_q[c]  <= reg_wdata[0];
          dn_q[c]  <= reg_wdata[1];
          dur_q[c] <= reg_wdata[2];
          sel_q[c] <= reg_wdata[7:4];
          ovf_q[c] <= 1'b0;
          unf_q[c] <= 1'b0;
        end
        if (snap_cmd) snap_q[c] <= cnt_q[c];
      end

    a_r5_saturate_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[c] == CMAX && en_q[c] && !dn_q[c] && !ld[c]) |=> cnt_q[c] == CMAX);
    a_r5_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovf_q[c] || unf_q[c]) && !cw[c]) |=> (ovf_q[c] || unf_q[c]));
    a_r4_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[c] && !ld[c]) |=> $stable(cnt_q[c]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_busy <= 1'b0;
      st_ptr  <= '0;
    end else if (stream_cmd) begin
      st_busy <= 1'b1;
      st_ptr  <= '0;
    end else if (st_busy) begin
      st_ptr <= st_ptr + 1'b1;
      if (st_ptr == IW'(NCTR-1)) st_busy <= 1'b0;
    end

  assign st_valid = st_busy;
  assign st_id    = MASTER_ID;
  assign st_idx   = st_ptr;
  assign st_data  = snap_q[st_ptr];

  a_r9_beats_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_idx != IW'(NCTR-1) && !stream_cmd) |=> (st_valid && st_idx == IW'($past(st_idx) + 1'b1)));

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NEV; i++)
      if (idx == 4'(i)) begin
        if (region == 4'd0) reg_rdata = DW'(mask_q[i]);
        if (region == 4'd1) reg_rdata = DW'(match_q[i]);
      end
    for (int i = 0; i < NCTR; i++)
      if (idx == 4'(i)) begin
        if (region == 4'd2) begin
          reg_rdata[0]   = en_q[i];
          reg_rdata[1]   = dn_q[i];
          reg_rdata[2]   = dur_q[i];
          reg_rdata[7:4] = sel_q[i];
          reg_rdata[8]   = ovf_q[i];
          reg_rdata[9]   = unf_q[i];
        end
        if (region == 4'd3) reg_rdata = DW'(cnt_q[i]);
        if (region == 4'd4) reg_rdata = DW'(snap_q[i]);
      end
  end
endmodule

// File: tb/tb_evt_count_bank.sv
module tb_evt_count_bank;
  localparam int PERIOD = 10;
  localparam int NV = 7;
  localparam logic [31:0] V_MASK [NV] = '{32'h0, 32'hFF, 32'hFF, 32'hF000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0001_0000};
  localparam logic [31:0] V_MATCH[NV] = '{32'hFFFF_FFFF, 32'h5A, 32'h5A, 32'hA000_0000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0};
  localparam logic [31:0] V_SMP  [NV] = '{32'h0, 32'h1234_565A, 32'h1234_565B, 32'hAFFF_FFFF, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 32'hFFFE_FFFF};
  localparam logic        V_HIT  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  logic clk = 0, rst_n = 0;
  logic [31:0] smp_in = '0;
  logic [3:0]  lane_alive = 4'hF;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        st_valid;
  logic [3:0]  st_id;
  logic [1:0]  st_idx;
  logic [15:0] st_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] v;

  always #(PERIOD/2) clk = ~clk;

  evt_count_bank dut (.clk, .rst_n, .smp_in, .lane_alive, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .st_valid, .st_id, .st_idx, .st_data);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #(PERIOD*20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h30, v); check("R10 counter0", v, 0);
    rd(8'h20, v); check("R10 ctrl0", v, 0);
    rd(8'h00, v); check("R10 mask0", v, 0);
    rd(8'h42, v); check("R10 snap2", v, 0);
    check("R10 st_valid", {31'b0, st_valid}, 0);

    // R1 vector table, counter0 duration up on event0
    wr(8'h20, 32'h05);
    for (int i = 0; i < NV; i++) begin
      wr(8'h00, V_MASK[i]);
      wr(8'h10, V_MATCH[i]);
      smp_in = V_SMP[i];
      repeat (2) @(negedge clk);
      wr(8'h30, 0);
      repeat (5) @(posedge clk);
      @(negedge clk);
      rd(8'h30, v); check($sformatf("R1 vector %0d", i), v, V_HIT[i] ? 5 : 0);
    end

    // R2/R3/R11: same pulse train, occurrence vs duration vs bad selector
    smp_in = 0;
    wr(8'h01, 32'h1); wr(8'h11, 32'h1);
    wr(8'h21, 32'h11); wr(8'h22, 32'h15); wr(8'h23, 32'h95);
    repeat (2) @(negedge clk);
    wr(8'h31, 0); wr(8'h32, 0); wr(8'h33, 0);
    for (int p = 0; p < 3; p++) begin
      smp_in[0] = 1; repeat (2) @(negedge clk);
      smp_in[0] = 0; repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    rd(8'h31, v); check("R2 occurrence count", v, 3);
    rd(8'h32, v); check("R3 duration count", v, 6);
    rd(8'h33, v); check("R11 out-of-range selector", v, 0);

    // R4/R5 down counting, underflow, flag clear
    wr(8'h00, 0);
    wr(8'h20, 32'h04);
    wr(8'h30, 3);
    repeat (4) @(negedge clk);
    rd(8'h30, v); check("R4 disabled holds", v, 3);
    wr(8'h20, 32'h07);
    repeat (2) @(posedge clk); @(negedge clk);
    rd(8'h30, v); check("R4 down count", v, 1);
    repeat (8) @(negedge clk);
    rd(8'h30, v); check("R5 floor at zero", v, 0);
    rd(8'h20, v); check("R5 underflow flag", v, 32'h207);
    wr(8'h20, 32'h04);
    rd(8'h20, v); check("R5 flags cleared", v, 32'h004);

    // R5 overflow
    wr(8'h30, 32'hFFFD);
    wr(8'h20, 32'h05);
    repeat (10) @(negedge clk);
    rd(8'h30, v); check("R5 ceiling", v, 32'hFFFF);
    rd(8'h20, v); check("R5 overflow flag", v, 32'h105);

    // R6 preset priority while counting
    wr(8'h30, 100);
    rd(8'h30, v); check("R6 preset wins", v, 100);
    @(negedge clk);
    rd(8'h30, v); check("R6 counting resumes", v, 101);

    // R7 dead lane
    wr(8'h02, 32'h1); wr(8'h12, 32'h1); wr(8'h22, 32'h25);
    smp_in = 0;
    repeat (2) @(negedge clk);
    wr(8'h32, 0);
    lane_alive = 4'b1110; smp_in[0] = 1;
    repeat (5) @(negedge clk);
    rd(8'h32, v); check("R7 dead lane ignored", v, 0);
    lane_alive = 4'hF;
    repeat (3) @(negedge clk);
    rd(8'h32, v); check("R7 capture resumes", v, 2);

    // R8 snapshot
    for (int c = 0; c < 4; c++) wr(8'h20 + 8'(c), 0);
    for (int c = 0; c < 4; c++) wr(8'h30 + 8'(c), 11 * (c + 1));
    wr(8'h50, 1);
    for (int c = 0; c < 4; c++) wr(8'h30 + 8'(c), 0);
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(c), v); check($sformatf("R8 snapshot %0d", c), v, 11 * (c + 1));
    end

    // R9 stream
    for (int c = 0; c < 4; c++) wr(8'h30 + 8'(c), 5 + c);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h50; reg_wdata = 32'h2;
    @(negedge clk);
    reg_we = 0;
    for (int c = 0; c < 4; c++) begin
      check("R9 beat valid", {31'b0, st_valid}, 1);
      check("R9 beat index", {30'b0, st_idx}, c);
      check("R9 beat data", {16'b0, st_data}, 5 + c);
      check("R9 master id", {28'b0, st_id}, 2);
      @(negedge clk);
    end
    check("R9 stream ends", {31'b0, st_valid}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end
endmodule